// File: doc/BRIEF.md
# Write-Cycle Status Readback for a Parallel EEPROM

This block reproduces, at the logic level, the way a byte-wide parallel EEPROM lets a host find out whether an internal programming cycle is still running. The host only uses ordinary read accesses to do this. When a byte or page write is launched, the block opens a busy window whose length is a parameter counted in clock cycles. It also keeps a copy of the byte that was written last.

While the window is open, a read does not return array contents. It returns a status byte made of three parts. Bit 7 is the inverse of bit 7 of the kept byte. Bit 6 changes value from one read to the next. Bits 5 to 0 are zero. When the window closes, reads pass the array data through unchanged, and the host can launch the next write.

The non-volatile storage and the programming circuitry sit outside this block. The array contents arrive on an input port, and the block only forms the byte that the read returns.

Top module: `wstat_top`

## Requirements
- R1: During reset and on the first cycle after it, `busy` is 0 and `rdData` is 0. The internal toggle state starts at 0, so the first status read after reset returns bit 6 = 0.
- R2: A `wrStart` pulse that arrives while idle raises `busy` on the next cycle. `busy` then stays high for exactly WRITE_CYCLES cycles and falls by itself.
- R3: A read that is sampled while `busy` is high returns bit 7 equal to the inverse of bit 7 of the `wrData` value captured with the accepted `wrStart`.
- R4: Bit 6 of the status byte carries the toggle state. Each read while busy flips that state, so successive busy reads return alternating bit-6 values.
- R5: A read while busy returns bits 5 to 0 as zero.
- R6: A read sampled while `busy` is low returns all eight bits of `arrayData` as they were at that edge. This includes a read in the same cycle as an accepted `wrStart`.
- R7: Reads while idle do not change the toggle state. The first busy read of a later write returns bit 6 as the inverse of the bit 6 returned by the last busy read of the write before it.
- R8: A `wrStart` that arrives while busy is ignored. It neither restarts nor extends the window, and it does not replace the kept byte.
- R9: A new write may be accepted on the first cycle in which `busy` is low after a window closes.
- R10: `rdData` is registered. It changes only on the clock edge that samples `rdStrobe` high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrStart | input | 1 | One-cycle pulse that starts a byte or page write |
| wrData | input | 8 | Last byte of the write, captured with an accepted `wrStart` |
| rdStrobe | input | 1 | Read access strobe |
| arrayData | input | 8 | Array contents at the address being read |
| rdData | output | 8 | Byte returned by the most recent read |
| busy | output | 1 | High while the write cycle timer runs |

## Verification
The assertions assume three things about the inputs. `rdStrobe` and `wrStart` are sampled only on rising edges. `wrData` and `arrayData` are stable at those edges. Reset is held for at least one edge before any activity starts. The bench changes every input half a period away from the sampling edge and holds reset low for several cycles. It places reads on the first and the last busy cycle, in the same cycle as a write start, and right after the window closes, so every check sits on an edge whose expected value is fixed.

// File: rtl/wstat_pkg.sv
package wstat_pkg;

  localparam int DATA_W     = 8;
  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;

  typedef struct packed {
    logic loadByte;
    logic selStatus;
    logic captureRead;
    logic flipToggle;
  } wstat_ctl_t;

endpackage

// File: rtl/wstat_ctrl.sv
module wstat_ctrl
  import wstat_pkg::*;
#(
  parameter int WRITE_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStart,
  input  logic       rdStrobe,
  output wstat_ctl_t ctl,
  output logic       busy
);

  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] cycleCnt;
  logic             acceptWrite;
  logic             timerDone;

  assign acceptWrite = wrStart && !busy;
  assign timerDone   = busy && (cycleCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cycleCnt <= '0;
    end else if (acceptWrite) begin
      busy     <= 1'b1;
      cycleCnt <= LAST_CNT;
    end else if (timerDone) begin
      busy     <= 1'b0;
    end else if (busy) begin
      cycleCnt <= cycleCnt - CNT_W'(1);
    end
  end

  always_comb begin
    ctl.loadByte    = acceptWrite;
    ctl.selStatus   = busy;
    ctl.captureRead = rdStrobe;
    ctl.flipToggle  = rdStrobe && busy;
  end

  // R2: an accepted start opens the window on the next cycle
  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    (wrStart && !busy) |=> busy);

  // R2: the window closes right after the count reaches zero
  a_r2_busy_fall: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cycleCnt == '0) |=> !busy);

  // R8: a start pulse during the window does not reload the timer
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cycleCnt != '0) |=> (busy && cycleCnt == $past(cycleCnt) - CNT_W'(1)));

endmodule

// File: rtl/wstat_datapath.sv
module wstat_datapath
  import wstat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wstat_ctl_t        ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] lastByte;
  logic              toggleQ;
  logic [DATA_W-1:0] statusByte;
  logic [DATA_W-1:0] nextRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastByte <= '0;
    end else if (ctl.loadByte) begin
      lastByte <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toggleQ <= 1'b0;
    end else if (ctl.flipToggle) begin
      toggleQ <= !toggleQ;
    end
  end

  always_comb begin
    statusByte             = '0;
    statusByte[POLL_BIT]   = !lastByte[POLL_BIT];
    statusByte[TOGGLE_BIT] = toggleQ;
    nextRead = ctl.selStatus ? statusByte : arrayData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.captureRead) begin
      rdData <= nextRead;
    end
  end

  // R3: polling bit is the inverse of the kept byte's top bit
  a_r3_poll_bit: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.captureRead && ctl.selStatus) |=> (rdData[POLL_BIT] == !$past(lastByte[POLL_BIT])));

  // R4: every busy read flips the toggle state
  a_r4_toggle_flip: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flipToggle |=> (toggleQ != $past(toggleQ)));

  // R5: low status bits are zero
  a_r5_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.captureRead && ctl.selStatus) |=> (rdData[5:0] == 6'd0));

  // R6: idle reads pass array data through
  a_r6_true_data: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.captureRead && !ctl.selStatus) |=> (rdData == $past(arrayData)));

  // R7: toggle state is frozen outside busy reads
  a_r7_toggle_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.flipToggle |=> $stable(toggleQ));

  // R10: output holds when no read is sampled
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.captureRead |=> $stable(rdData));

endmodule

// File: rtl/wstat_top.sv
module wstat_top
  import wstat_pkg::*;
#(
  parameter int WRITE_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStart,
  input  logic [7:0] wrData,
  input  logic       rdStrobe,
  input  logic [7:0] arrayData,
  output logic [7:0] rdData,
  output logic       busy
);

  wstat_ctl_t ctl;

  wstat_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrStart  (wrStart),
    .rdStrobe (rdStrobe),
    .ctl      (ctl),
    .busy     (busy)
  );

  wstat_datapath i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wrData    (wrData),
    .arrayData (arrayData),
    .rdData    (rdData)
  );

endmodule

// File: tb/test_wstat_top.sv
module test_wstat_top;

  localparam int CLK_PERIOD = 10;
  localparam int WCYC       = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStart = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdStrobe = 1'b0;
  logic [7:0] arrayData = '0;
  logic [7:0] rdData;
  logic       busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] value;
    string      tag;
  } exp_t;

  exp_t expQ[$];

  // reference model state
  bit         mBusy = 0;
  int         mLeft = 0;
  logic [7:0] mByte = '0;
  bit         mTog = 0;
  logic [7:0] mOut = '0;
  logic       lastBit6 = 1'b0;

  wstat_top #(.WRITE_CYCLES(WCYC)) i_wstat_top (
    .clk       (clk),
    .rstN      (rstN),
    .wrStart   (wrStart),
    .wrData    (wrData),
    .rdStrobe  (rdStrobe),
    .arrayData (arrayData),
    .rdData    (rdData),
    .busy      (busy)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, advance model, check busy/hold after edge
  task automatic step(input bit ws, input logic [7:0] wd, input bit rd, input string tag);
    exp_t e;
    logic [7:0] arr;
    @(negedge clk);
    arr = 8'($urandom);
    wrStart = ws; wrData = wd; rdStrobe = rd; arrayData = arr;
    if (rd) begin
      if (mBusy) begin
        e.value = {~mByte[7], mTog, 6'b0};
        mTog = !mTog;
      end else begin
        e.value = arr;
      end
      e.tag = tag;
      mOut = e.value;
      expQ.push_back(e);
    end
    if (mBusy) begin
      if (mLeft == 1) mBusy = 0;
      else mLeft--;
    end else if (ws) begin
      mBusy = 1; mLeft = WCYC; mByte = wd;
    end
    @(posedge clk); #1;
    check(busy == mBusy, "R2 busy", {7'd0, busy}, {7'd0, mBusy});
    if (!rd) check(rdData == mOut, "R10 hold", rdData, mOut);
  endtask

  // monitor: pops expected read results after each sampled read
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (rstN && rdStrobe) begin
        #1;
        if (expQ.size() == 0) begin
          check(1'b0, "scoreboard underflow", rdData, 8'h00);
        end else begin
          e = expQ.pop_front();
          check(rdData == e.value, e.tag, rdData, e.value);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(busy == 1'b0, "R1 busy in reset", {7'd0, busy}, 8'h00);
    check(rdData == 8'h00, "R1 data in reset", rdData, 8'h00);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check(busy == 1'b0 && rdData == 8'h00, "R1 after reset", rdData, 8'h00);

    // idle reads pass array data
    step(0, 8'h00, 1, "R6 idle read");
    step(0, 8'h00, 1, "R6 idle read 2");
    step(0, 8'h00, 0, "");
    // read in same cycle as start returns array data
    step(1, 8'hA5, 1, "R6 read with start");
    // first busy read: toggle 0 after reset, bit7 inverted
    step(0, 8'h00, 1, "R1 R3 R4 R5 first busy read");
    step(0, 8'h00, 1, "R4 second busy read");
    // start during busy with other data: ignored
    step(1, 8'h13, 1, "R8 start while busy");
    for (int i = 0; i < WCYC - 4; i++) step(0, 8'h00, (i % 2), "R4 busy read");
    // last busy cycle
    step(0, 8'h00, 1, "R2 R3 last busy read");
    lastBit6 = !mTog;
    // window closed: true data, toggle frozen
    step(0, 8'h00, 1, "R6 read after window");
    step(0, 8'h00, 1, "R7 idle read");
    step(0, 8'h00, 0, "");
    // second write with bit7 clear
    step(1, 8'h3C, 0, "");
    step(0, 8'h00, 1, "R7 R3 first read of new write");
    check(rdData[6] == !lastBit6, "R7 bit6 continuity", {7'd0, rdData[6]}, {7'd0, !lastBit6});
    while (mBusy) step(0, 8'h00, 1, "R4 polling loop");
    // immediate new write on first idle cycle
    step(1, 8'hFF, 0, "R9 write on first idle cycle");
    step(0, 8'h00, 1, "R9 R3 busy read after rewrite");
    while (mBusy) step(0, 8'h00, 0, "");
    step(0, 8'h00, 1, "R6 final idle read");
    step(0, 8'h00, 0, "");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule